// File: doc/BRIEF.md
# Signed Two's-Complement Array Multiplier

This block multiplies two N-bit two's-complement operands and returns their full 2N-bit two's-complement product. Signed operands are handled without sign-extension rows and without recoding. Every partial-product bit in which exactly one of the two factor bits is a sign bit is fed in inverted, as a NAND of the two bits. The product of the two sign bits and all bits that involve no sign bit are plain ANDs. Two constant ones, at bit N and at bit 2N-1, absorb the offset that the inversion creates. The top bit of the result then carries negative weight, which gives an ordinary two's-complement number.

The partial products are summed in a regular one-sided array. Each row of full-adder cells folds one multiplier bit's row of AND/NAND terms into a running carry-save pair. The first row is seeded with the constant ones. A final ripple-carry adder collapses the pair into the product. The `PIPELINED` parameter picks the build. With 0 the array is purely combinational, `out_valid` mirrors `in_valid` and the product belongs to the operands on the inputs. With 1 (the default) a register bank follows every adder row. The block then accepts one operand pair per clock and presents its result exactly N cycles later, tagged by `out_valid`. N defaults to 5 and must be at least 3.

Top module: `bw_array_mult`

## Requirements
- R1: For every pair of N-bit two's-complement operands, `product` equals their signed product as a 2N-bit two's-complement value.
- R2: With PIPELINED=1, `out_valid` is high exactly N clock cycles after a cycle in which `in_valid` was sampled high, and low otherwise. With PIPELINED=0, `out_valid` equals `in_valid` in the same cycle.
- R3: With PIPELINED=1, a new operand pair can be presented on every clock cycle, and results leave in the order the pairs were accepted, with no stall and no gap.
- R4: While `rst_n` is low, a pipelined instance drives `out_valid` and `product` to zero. Operand pairs accepted before reset, and pairs presented while reset is low, never produce a valid result.
- R5: The most negative operand times itself (-2^(N-1) × -2^(N-1)) gives +2^(2N-2), with bit 2N-1 clear.
- R6: When either operand is zero, the product is zero.
- R7: When both operands are nonzero, bit 2N-1 of the product equals the XOR of the two operand sign bits (bit N-1).
- R8: Each adder row preserves the carry-save total. The sum plus carry that it emits equals, modulo 2^(2N), the sum plus carry it received plus its own row of partial-product terms placed at the row's bit offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the pipeline registers (rising edge) |
| rst_n | input | 1 | Asynchronous active-low reset of the pipeline registers |
| in_valid | input | 1 | Marks a cycle that carries an operand pair |
| a_in | input | N | Multiplicand, two's complement |
| b_in | input | N | Multiplier, two's complement |
| out_valid | output | 1 | Marks a cycle that carries a finished product |
| product | output | 2N | Signed product, two's complement |

## Verification
The two functions that share a cycle are accepting a new operand pair at the top of the array and emitting an older pair's result at the bottom. In the pipelined build this happens on every cycle of a back-to-back stream. The bench drives all 1024 pairs for N=5 with no gaps, including the most negative operand squared. Each emitted product must match the head of a queue of behaviourally computed products that is due in that exact cycle. A gapped stream then checks that idle cycles propagate as idle outputs. A reset asserted while the pipeline is full checks that no in-flight pair later surfaces. A combinational instance is compared against the same reference within each cycle.

// File: rtl/bw_mult_pkg.sv
package bw_mult_pkg;

    // True when exactly one of the two factor indices is the sign position:
    // such a partial-product term enters the array inverted.
    function automatic bit is_cross_term(input int i, input int j, input int n);
        return (i == n - 1) != (j == n - 1);
    endfunction

    // Correction constant: ones at weight n and weight 2n-1.
    function automatic bit is_const_one(input int k, input int n);
        return (k == n) || (k == 2 * n - 1);
    endfunction

endpackage

// File: rtl/bw_fa_cell.sv
module bw_fa_cell (
    input  logic a,
    input  logic b,
    input  logic ci,
    output logic s,
    output logic co
);
    assign s  = a ^ b ^ ci;
    assign co = (a & b) | (a & ci) | (b & ci);
endmodule

// File: rtl/bw_pp_row.sv
module bw_pp_row #(
    parameter int N = 5,
    parameter int J = 0
) (
    input  logic [N-1:0] a,
    input  logic         x_bit,
    output logic [N-1:0] pp
);
    import bw_mult_pkg::*;

    for (genvar i = 0; i < N; i++) begin : g_term
        if (is_cross_term(i, J, N)) begin : g_nand
            assign pp[i] = ~(a[i] & x_bit);
        end else begin : g_and
            assign pp[i] = a[i] & x_bit;
        end
    end
endmodule

// File: rtl/bw_ripple_add.sv
module bw_ripple_add #(
    parameter int W = 10
) (
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    output logic [W-1:0] sum
);
    logic [W-1:0] carry;

    assign carry[0] = 1'b0;
    for (genvar k = 0; k < W; k++) begin : g_bit
        if (k == W - 1) begin : g_top
            assign sum[k] = op_a[k] ^ op_b[k] ^ carry[k];
        end else begin : g_fa
            bw_fa_cell fa_i (
                .a (op_a[k]),
                .b (op_b[k]),
                .ci(carry[k]),
                .s (sum[k]),
                .co(carry[k+1])
            );
        end
    end
endmodule

// File: rtl/bw_csa_row.sv
module bw_csa_row #(
    parameter int N   = 5,
    parameter int J   = 0,
    parameter bit REG = 1'b1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           vld_i,
    input  logic [N-1:0]   a_i,
    input  logic [N-1:0]   x_i,
    input  logic [2*N-1:0] sum_i,
    input  logic [2*N-1:0] cry_i,
    output logic           vld_o,
    output logic [N-1:0]   a_o,
    output logic [N-1:0]   x_o,
    output logic [2*N-1:0] sum_o,
    output logic [2*N-1:0] cry_o
);
    localparam int W = 2 * N;

    logic [N-1:0] pp;
    logic [W-1:0] addend;
    logic [W-1:0] sum_n;
    logic [W-1:0] cry_n;

    bw_pp_row #(.N(N), .J(J)) pp_i (
        .a    (a_i),
        .x_bit(x_i[J]),
        .pp   (pp)
    );

    for (genvar k = 0; k < W; k++) begin : g_place
        if (k >= J && k < J + N) begin : g_pp
            assign addend[k] = pp[k-J];
        end else begin : g_zero
            assign addend[k] = 1'b0;
        end
    end

    assign cry_n[0] = 1'b0;
    for (genvar k = 0; k < W; k++) begin : g_cell
        if (k == W - 1) begin : g_top
            assign sum_n[k] = sum_i[k] ^ cry_i[k] ^ addend[k];
        end else begin : g_fa
            bw_fa_cell fa_i (
                .a (sum_i[k]),
                .b (cry_i[k]),
                .ci(addend[k]),
                .s (sum_n[k]),
                .co(cry_n[k+1])
            );
        end
    end

    if (REG) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                vld_o <= 1'b0;
                a_o   <= '0;
                x_o   <= '0;
                sum_o <= '0;
                cry_o <= '0;
            end else begin
                vld_o <= vld_i;
                a_o   <= a_i;
                x_o   <= x_i;
                sum_o <= sum_n;
                cry_o <= cry_n;
            end
        end

        // R8: the registered carry-save pair holds last cycle's total plus this row's terms
        assert_row_total_R8: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> (W'(sum_o + cry_o) == $past(W'(sum_i + cry_i + addend))));
    end else begin : g_comb
        assign vld_o = vld_i;
        assign a_o   = a_i;
        assign x_o   = x_i;
        assign sum_o = sum_n;
        assign cry_o = cry_n;

        // R8: the cell outputs carry the incoming total plus this row's terms
        assert_row_total_R8: assert property (@(posedge clk) disable iff (!rst_n)
            W'(sum_o + cry_o) == W'(sum_i + cry_i + addend));
    end
endmodule

// File: rtl/bw_array_mult.sv
module bw_array_mult #(
    parameter int N         = 5,
    parameter bit PIPELINED = 1'b1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_valid,
    input  logic [N-1:0]   a_in,
    input  logic [N-1:0]   b_in,
    output logic           out_valid,
    output logic [2*N-1:0] product
);
    import bw_mult_pkg::*;

    localparam int W = 2 * N;

    logic [W-1:0] seed;
    logic         vld_s [0:N];
    logic [N-1:0] a_s   [0:N];
    logic [N-1:0] x_s   [0:N];
    logic [W-1:0] sum_s [0:N];
    logic [W-1:0] cry_s [0:N];

    for (genvar k = 0; k < W; k++) begin : g_seed
        assign seed[k] = is_const_one(k, N);
    end

    assign vld_s[0] = in_valid;
    assign a_s[0]   = a_in;
    assign x_s[0]   = b_in;
    assign sum_s[0] = seed;
    assign cry_s[0] = '0;

    for (genvar j = 0; j < N; j++) begin : g_row
        bw_csa_row #(.N(N), .J(j), .REG(PIPELINED)) row_i (
            .clk  (clk),
            .rst_n(rst_n),
            .vld_i(vld_s[j]),
            .a_i  (a_s[j]),
            .x_i  (x_s[j]),
            .sum_i(sum_s[j]),
            .cry_i(cry_s[j]),
            .vld_o(vld_s[j+1]),
            .a_o  (a_s[j+1]),
            .x_o  (x_s[j+1]),
            .sum_o(sum_s[j+1]),
            .cry_o(cry_s[j+1])
        );
    end

    bw_ripple_add #(.W(W)) cpa_i (
        .op_a(sum_s[N]),
        .op_b(cry_s[N]),
        .sum (product)
    );

    assign out_valid = vld_s[N];

    // R6: a zero factor at the array exit yields a zero product
    assert_zero_factor_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && (a_s[N] == '0 || x_s[N] == '0)) |-> (product == '0));

    // R7: nonzero factors give a result sign equal to the XOR of operand signs
    assert_sign_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && a_s[N] != '0 && x_s[N] != '0)
        |-> (product[W-1] == (a_s[N][N-1] ^ x_s[N][N-1])));

    // R5: most negative squared is +2^(2N-2)
    assert_min_square_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && a_s[N] == {1'b1, {(N-1){1'b0}}} && x_s[N] == {1'b1, {(N-1){1'b0}}})
        |-> (product == (W'(1) << (W - 2))));
endmodule

// File: tb/bw_array_mult_tb_top.sv
`timescale 1ns/1ps
module bw_array_mult_tb_top;
    localparam int N     = 5;
    localparam int W     = 2 * N;
    localparam int DEPTH = N;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic         rst_n    = 1'b0;
    logic         in_valid = 1'b0;
    logic [N-1:0] a_in     = '0;
    logic [N-1:0] b_in     = '0;
    logic         pv, cv;
    logic [W-1:0] pp, cp;

    bw_array_mult #(.N(N), .PIPELINED(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .a_in(a_in), .b_in(b_in), .out_valid(pv), .product(pp)
    );

    bw_array_mult #(.N(N), .PIPELINED(1'b0)) dut_comb_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .a_in(a_in), .b_in(b_in), .out_valid(cv), .product(cp)
    );

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit done  = 1'b0;
    logic [W-1:0] exp_q [$];
    int           due_q [$];

    function automatic int sval(input logic [N-1:0] v);
        return v[N-1] ? int'(v) - (1 << N) : int'(v);
    endfunction

    function automatic logic [W-1:0] ref_prod(input logic [N-1:0] a, input logic [N-1:0] b);
        int p;
        p = sval(a) * sval(b);
        return W'(p);
    endfunction

    function automatic string tag_for(input logic [N-1:0] a, input logic [N-1:0] b);
        if (a == {1'b1, {(N-1){1'b0}}} && b == {1'b1, {(N-1){1'b0}}}) return "R5";
        if (a == '0 || b == '0) return "R6";
        return "R1 R8";
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s cycle=%0d actual=%h expected=%h", req, cyc, act, exp);
        end
    endtask

    task automatic compare();
        // combinational build: same-cycle result and valid
        check(tag_for(a_in, b_in), 32'(cp), 32'(ref_prod(a_in, b_in)));
        check("R2 comb", 32'(cv), 32'(in_valid));
        if (a_in != '0 && b_in != '0)
            check("R7", 32'(cp[W-1]), 32'(a_in[N-1] ^ b_in[N-1]));
        // pipelined build
        if (!rst_n) begin
            check("R4 valid", 32'(pv), 32'd0);
            check("R4 product", 32'(pp), 32'd0);
        end else if (due_q.size() > 0 && due_q[0] == cyc) begin
            check("R2", 32'(pv), 32'd1);
            check("R3", 32'(pp), 32'(exp_q[0]));
            void'(exp_q.pop_front());
            void'(due_q.pop_front());
        end else begin
            check("R2 idle", 32'(pv), 32'd0);
        end
    endtask

    task automatic step();
        @(negedge clk);
        cyc++;
        compare();
    endtask

    task automatic drive(input logic [N-1:0] a, input logic [N-1:0] b, input logic v);
        a_in     = a;
        b_in     = b;
        in_valid = v;
        if (v && rst_n) begin
            exp_q.push_back(ref_prod(a, b));
            due_q.push_back(cyc + DEPTH);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        // R4: reset state
        for (int i = 0; i < 3; i++) begin
            step();
            drive(N'(i + 3), N'(i + 7), 1'b1);
        end
        step();
        rst_n = 1'b1;
        drive('0, '0, 1'b0);

        // R1 R3 R5 R6 R7: exhaustive back-to-back stream
        for (int ai = 0; ai < (1 << N); ai++) begin
            for (int bi = 0; bi < (1 << N); bi++) begin
                step();
                drive(N'(ai), N'(bi), 1'b1);
            end
        end

        // R2: gapped stream
        for (int i = 0; i < 60; i++) begin
            step();
            drive(N'(i * 13 + 5), N'(i * 11 + 3), 1'b1 ^ ((i % 3) == 1) ^ ((i % 7) == 4));
        end
        for (int i = 0; i < DEPTH + 2; i++) begin
            step();
            drive('0, '0, 1'b0);
        end

        // R4: reset while the pipeline holds work
        for (int i = 0; i < 3; i++) begin
            step();
            drive(N'(i + 9), N'(i + 2), 1'b1);
        end
        step();
        rst_n = 1'b0;
        exp_q.delete();
        due_q.delete();
        drive(N'(6), N'(5), 1'b1);
        step();
        step();
        rst_n = 1'b1;
        drive('0, '0, 1'b0);
        for (int i = 0; i < DEPTH + 3; i++) begin
            step();
        end
        check("R4 drained", 32'(exp_q.size()), 32'd0);

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog cycle=%0d actual=running expected=finished", cyc);
            summary();
            $finish;
        end
    end
endmodule